// File: doc/BRIEF.md
# Parallel Adler-32 Checksum Engine

This block computes an Adler-32 checksum over a byte stream that arrives as wide beats. Each beat carries up to sixteen bytes, with lane 0 being the earliest byte of the beat. A per-beat byte count marks how many leading lanes are live, so a short final beat or a short beat mid-stream is absorbed exactly. In one clock the engine folds a whole beat into its two 32-bit running sums. The plain sum `a` grows by the total of the live bytes. The weighted sum `b` grows by `n` times the old `a`, plus each live byte scaled by its distance from the end of the beat (`n-i` for lane `i`). This gives the same result as stepping the bytes one at a time.

Reduction modulo 65521 is deferred. A byte counter tracks how many bytes have been folded since the last reduction. The sums are reduced whenever that counter gets close enough to the 5552-byte bound that one more full beat could push it past. This keeps both 32-bit sums from wrapping. A reduction is also always applied on the beat that closes a message. Reduction uses the identity 2^16 ≡ 15 (mod 65521), so it needs only shifts, small multiplies by a constant and a final compare-subtract. No divider is involved.

A message begins with a start pulse that loads both sums from seed inputs; a beat presented in the same cycle folds onto the seeds. Normal use seeds 1 and 0, while a checksum can be continued across buffers by seeding with the two halves of an earlier result.

Top module: `adler32_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_o` is 0 and `sum_o` is 0.
- R2: A cycle with `start_i` high loads `a` from `seed_adler_i` and `b` from `seed_sum2_i`. A beat valid in that same cycle is folded onto the seeded values.
- R3: A valid beat contributes the bytes in lanes 0 to n-1, in that order, where lane i occupies `beat_data_i[8i+7:8i]`. The result equals the byte-serial rule: `a += byte`, then `b += a`.
- R4: `beat_cnt_i` gives the number of live lanes. The value 0 contributes no bytes, values above 16 act as 16, and data in lanes at or above the count has no effect on the result.
- R5: One cycle after the edge that accepts a valid beat with `beat_last_i` high, `done_o` is high for exactly one cycle. `done_o` is low in every other cycle.
- R6: `sum_o` equals `{b mod 65521, a mod 65521}`, with b in bits 31:16 and a in bits 15:0. It is updated only together with `done_o` and holds its value between completions.
- R7: Messages of any length, including runs of bytes of value 0xFF far beyond 5552 bytes and mixed partial beats, produce the exact checksum. The byte counter since the last reduction never exceeds 5552.
- R8: Both 16-bit fields of `sum_o` are below 65521 whenever `done_o` is high, including when seeds of 65521 or more were loaded.
- R9: Cycles with `beat_valid_i` low leave the running sums unchanged, whatever appears on the data, count and last inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a message: load the seeds |
| seed_adler_i | input | 16 | Starting value of the plain sum |
| seed_sum2_i | input | 16 | Starting value of the weighted sum |
| beat_valid_i | input | 1 | The beat on the data inputs is live this cycle |
| beat_data_i | input | 128 | Sixteen byte lanes, lane 0 in bits 7:0 |
| beat_cnt_i | input | 5 | Number of live leading lanes (0 to 16, larger acts as 16) |
| beat_last_i | input | 1 | This beat closes the message |
| sum_o | output | 32 | Packed checksum: weighted sum high, plain sum low |
| done_o | output | 1 | One-cycle strobe: `sum_o` holds a new checksum |

## Verification
Both outputs are registered on the edge that accepts the closing beat. `done_o` and the new `sum_o` are therefore due one edge after that beat is presented; they are read at the falling edge that follows, and `done_o` must be low again one edge later. The bench drives its inputs just after a rising edge. It derives the expected checksum from a byte-serial model at the moment it presents the closing beat, and switches its expectation over at that same edge. Every falling edge then compares both outputs with the expectation, so a strobe that comes early, late or twice is seen in the very cycle it occurs. A sum that drifts between completions is caught the same way.

// File: rtl/adler32_pkg.sv
`timescale 1ns/1ps
package adler32_pkg;
  localparam int ACC_W  = 32;
  localparam int HALF_W = 16;
  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/adler32_reduce.sv
`timescale 1ns/1ps
// Reduces a running sum modulo BASE using 2^HALF_W == K (mod BASE).
module adler32_reduce
  import adler32_pkg::*;
#(
  parameter int BASE = 65521
) (
  input  acc_t  x,
  output half_t r
);
  localparam int K = (1 << HALF_W) - BASE;

  acc_t s1, s2, s3, s4;

  always_comb begin
    s1 = acc_t'(x[ACC_W-1:HALF_W]) * acc_t'(K) + acc_t'(x[HALF_W-1:0]);
    s2 = acc_t'(s1[ACC_W-1:HALF_W]) * acc_t'(K) + acc_t'(s1[HALF_W-1:0]);
    s3 = (s2 >= acc_t'(BASE)) ? s2 - acc_t'(BASE) : s2;
    s4 = (s3 >= acc_t'(BASE)) ? s3 - acc_t'(BASE) : s3;
    r  = s4[HALF_W-1:0];
  end
endmodule

// File: rtl/adler32_fold.sv
`timescale 1ns/1ps
// Folds up to LANES bytes into the running sums in one step.
module adler32_fold
  import adler32_pkg::*;
#(
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input  acc_t                 acc_a,
  input  acc_t                 acc_b,
  input  logic [8*LANES-1:0]   data,
  input  logic [CNT_W-1:0]     nbytes,
  output acc_t                 nxt_a,
  output acc_t                 nxt_b
);
  acc_t plain_t [LANES];
  acc_t wtd_t   [LANES];
  acc_t sum_x, sum_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_byte;
    logic       live;
    assign lane_byte  = data[8*g +: 8];
    assign live       = CNT_W'(g) < nbytes;
    assign plain_t[g] = live ? acc_t'(lane_byte) : '0;
    assign wtd_t[g]   = live ? acc_t'(lane_byte) * acc_t'(nbytes - CNT_W'(g)) : '0;
  end

  always_comb begin
    sum_x = '0;
    sum_w = '0;
    for (int i = 0; i < LANES; i++) begin
      sum_x = sum_x + plain_t[i];
      sum_w = sum_w + wtd_t[i];
    end
    nxt_a = acc_a + sum_x;
    nxt_b = acc_b + acc_a * acc_t'(nbytes) + sum_w;
  end
endmodule

// File: rtl/adler32_engine.sv
`timescale 1ns/1ps
module adler32_engine
  import adler32_pkg::*;
#(
  parameter int  LANES   = 16,
  parameter int  BASE    = 65521,
  parameter int  RUN_MAX = 5552,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [15:0]        seed_adler_i,
  input  logic [15:0]        seed_sum2_i,
  input  logic               beat_valid_i,
  input  logic [8*LANES-1:0] beat_data_i,
  input  logic [CNT_W-1:0]   beat_cnt_i,
  input  logic               beat_last_i,
  output logic [31:0]        sum_o,
  output logic               done_o
);
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int RED_THR = RUN_MAX - LANES;

  acc_t             acc_a_q, acc_b_q;
  logic [RUN_W-1:0] run_q;

  acc_t             base_a, base_b, fold_a, fold_b;
  logic [RUN_W-1:0] run_base, run_nxt;
  logic [CNT_W-1:0] n_eff;
  half_t            red_a, red_b;
  logic             need_red, closing;

  always_comb begin
    n_eff    = (beat_cnt_i > CNT_W'(LANES)) ? CNT_W'(LANES) : beat_cnt_i;
    base_a   = start_i ? acc_t'(seed_adler_i) : acc_a_q;
    base_b   = start_i ? acc_t'(seed_sum2_i)  : acc_b_q;
    run_base = start_i ? '0 : run_q;
    run_nxt  = run_base + (beat_valid_i ? RUN_W'(n_eff) : '0);
    closing  = beat_valid_i && beat_last_i;
    need_red = closing || (beat_valid_i && (run_nxt > RUN_W'(RED_THR)));
  end

  adler32_fold #(.LANES(LANES), .CNT_W(CNT_W)) u_fold (
    .acc_a (base_a),
    .acc_b (base_b),
    .data  (beat_data_i),
    .nbytes(beat_valid_i ? n_eff : '0),
    .nxt_a (fold_a),
    .nxt_b (fold_b)
  );

  adler32_reduce #(.BASE(BASE)) u_red_a (.x(fold_a), .r(red_a));
  adler32_reduce #(.BASE(BASE)) u_red_b (.x(fold_b), .r(red_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a_q <= acc_t'(1);
      acc_b_q <= '0;
      run_q   <= '0;
      done_o  <= 1'b0;
      sum_o   <= '0;
    end else begin
      done_o <= closing;
      if (start_i || beat_valid_i) begin
        acc_a_q <= need_red ? acc_t'(red_a) : fold_a;
        acc_b_q <= need_red ? acc_t'(red_b) : fold_b;
        run_q   <= need_red ? '0 : run_nxt;
      end
      if (closing) sum_o <= {red_b, red_a};
    end
  end
endmodule

// File: rtl/adler32_engine_chk.sv
`timescale 1ns/1ps
module adler32_engine_chk #(
  parameter int BASE    = 65521,
  parameter int RUN_MAX = 5552,
  parameter int RUN_W   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_valid_i,
  input logic             beat_last_i,
  input logic [31:0]      sum_o,
  input logic             done_o,
  input logic [RUN_W-1:0] run_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done_o && sum_o == 32'd0)); // R1
  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_i && beat_last_i) |=> done_o); // R5
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    !(beat_valid_i && beat_last_i) |=> !done_o); // R5
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (rst)
    !(beat_valid_i && beat_last_i) |=> $stable(sum_o)); // R6
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(run_q) <= RUN_MAX); // R7
  AST_FIELDS_REDUCED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (int'(sum_o[15:0]) < BASE && int'(sum_o[31:16]) < BASE)); // R8
endmodule

bind adler32_engine adler32_engine_chk #(
  .BASE(BASE), .RUN_MAX(RUN_MAX), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rst(rst), .beat_valid_i(beat_valid_i), .beat_last_i(beat_last_i),
  .sum_o(sum_o), .done_o(done_o), .run_q(run_q)
);

// File: tb/adler32_engine_test.sv
`timescale 1ns/1ps
module adler32_engine_test;
  localparam int LANES = 16;
  localparam int BASE  = 65521;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [15:0]  seed_adler_i = 16'd1, seed_sum2_i = 16'd0;
  logic         beat_valid_i = 1'b0;
  logic [127:0] beat_data_i = '0;
  logic [4:0]   beat_cnt_i = '0;
  logic         beat_last_i = 1'b0;
  logic [31:0]  sum_o;
  logic         done_o;

  always #2.5 clk = ~clk;

  adler32_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_adler_i(seed_adler_i),
    .seed_sum2_i(seed_sum2_i), .beat_valid_i(beat_valid_i), .beat_data_i(beat_data_i),
    .beat_cnt_i(beat_cnt_i), .beat_last_i(beat_last_i), .sum_o(sum_o), .done_o(done_o)
  );

  int          n_checks = 0, n_err = 0;
  string       cur_req = "R3";
  bit          mon_on = 0, pend_done = 0, exp_done = 0;
  logic [31:0] pend_sum = '0, exp_sum = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  // Every-cycle comparison of both outputs against the expectation.
  always @(negedge clk) begin
    if (mon_on) begin
      check(done_o == exp_done, "R5", "done_o", done_o, exp_done);
      check(sum_o == exp_sum, exp_done ? cur_req : "R6", "sum_o", sum_o, exp_sum);
      if (done_o)
        check(sum_o[15:0] < BASE && sum_o[31:16] < BASE, "R8", "field range", sum_o, exp_sum);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    exp_done = pend_done;
    if (pend_done) exp_sum = pend_sum;
    pend_done = 0;
  endtask

  task automatic idle(int cycles);
    for (int k = 0; k < cycles; k++) begin
      beat_valid_i = 1'b0;
      start_i      = 1'b0;
      beat_data_i  = {$urandom, $urandom, $urandom, $urandom};
      beat_cnt_i   = 5'($urandom);
      beat_last_i  = 1'($urandom);   // R9: last without valid has no effect
      tick();
    end
  endtask

  // pat: 0 random bytes, 1 all 0xFF
  task automatic send_msg(int len, int pat, bit chop, bit gaps, bit big_cnt, bit sep_start,
                          logic [15:0] sa, logic [15:0] sb, string req);
    int     q[$];
    longint a, b;
    int     pos, n;
    bit     fin, first;
    cur_req = req;
    a = sa; b = sb;
    for (int i = 0; i < len; i++) begin
      q.push_back(pat == 1 ? 255 : int'($urandom % 256));
      a = (a + q[i]) % BASE;
      b = (b + a) % BASE;
    end
    a = a % BASE; b = b % BASE;
    seed_adler_i = sa; seed_sum2_i = sb;
    if (sep_start) begin
      start_i = 1'b1; beat_valid_i = 1'b0; beat_last_i = 1'b0;
      tick();
    end
    pos = 0; fin = 0; first = 1;
    while (!fin) begin
      n = (len - pos < LANES) ? len - pos : LANES;
      if (chop && ($urandom % 3 == 0)) n = int'($urandom % (n + 1));
      fin = (pos + n == len);
      beat_data_i = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < n; i++) beat_data_i[8*i +: 8] = 8'(q[pos + i]);
      beat_cnt_i = 5'(n);
      if (big_cnt && n == LANES) beat_cnt_i = 5'(LANES + 1 + ($urandom % 15));
      start_i      = first && !sep_start;
      beat_valid_i = 1'b1;
      beat_last_i  = fin;
      if (fin) begin
        pend_done = 1;
        pend_sum  = {16'(b), 16'(a)};
      end
      tick();
      first = 0;
      pos   = pos + n;
      if (gaps && !fin && ($urandom % 4 == 0)) idle(1 + int'($urandom % 3));
    end
    idle(2);
  endtask

  initial begin
    #(5.0 * 190000);
    n_err++;
    $display("FAIL R5 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(done_o == 1'b0, "R1", "done_o in reset", done_o, 0);
    check(sum_o == 32'd0, "R1", "sum_o in reset", sum_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    mon_on = 1;
    idle(3);                                                   // R1, R9: idle keeps zero

    send_msg(1,  0, 0, 0, 0, 0, 16'd1, 16'd0, "R3");
    send_msg(0,  0, 0, 0, 0, 0, 16'd1, 16'd0, "R4");           // zero count, last
    send_msg(15, 0, 0, 0, 0, 0, 16'd1, 16'd0, "R3");
    send_msg(16, 0, 0, 0, 0, 0, 16'd1, 16'd0, "R3");
    send_msg(17, 0, 0, 0, 0, 0, 16'd1, 16'd0, "R3");
    send_msg(33, 1, 0, 0, 0, 0, 16'd1, 16'd0, "R3");
    send_msg(300, 0, 1, 0, 0, 0, 16'd1, 16'd0, "R4");          // partial beats, garbage lanes
    send_msg(200, 0, 0, 0, 1, 0, 16'd1, 16'd0, "R4");          // counts above 16
    send_msg(100, 0, 0, 0, 0, 0, 16'h1234, 16'hABCD, "R2");    // seeded with beat
    send_msg(100, 0, 1, 0, 0, 1, 16'h0BEE, 16'h7001, "R2");    // seed-only cycle first
    send_msg(40, 0, 0, 0, 0, 1, 16'hFFFF, 16'hFFF5, "R8");     // seeds above modulus
    send_msg(250, 0, 1, 1, 0, 0, 16'd1, 16'd0, "R9");          // idle gaps mid-message
    send_msg(5552, 1, 0, 0, 0, 0, 16'd1, 16'd0, "R7");
    send_msg(5553, 1, 0, 0, 0, 0, 16'hFFF0, 16'hFFF0, "R7");
    send_msg(22000, 1, 1, 0, 0, 0, 16'd1, 16'd0, "R7");        // 0xFF, mixed beats
    for (int m = 0; m < 5; m++)
      send_msg(int'($urandom % 20500), 0, 1, 1, 1, 0, 16'd1, 16'd0, "R7");
    send_msg(20480, 1, 0, 0, 0, 0, 16'd1, 16'd0, "R7");

    mon_on = 0;
    summary();
    $finish;
  end
endmodule